// File: doc/BRIEF.md
# Floating-Point Compare and Min/Max Unit

This block takes two floating-point operand words and either orders them or picks one of them. A format select chooses single precision (1 sign, 8 exponent, 23 fraction bits) or double precision (1 sign, 11 exponent, 52 fraction bits). An operation select chooses equality, less-than, less-or-equal, minimum or maximum. Both formats go through one shared path. Each operand is first reduced to a format-free description: its sign, its magnitude bits, and whether it is zero, a NaN or a signaling NaN.

The compare operations return a one-bit answer in bit 0 of the result. Minimum and maximum return a whole operand. Whenever a NaN has to be produced, the block emits the one canonical quiet NaN of the selected format and never copies a payload from an input. An invalid-operation flag goes with every result. The block registers its outputs, so the answer arrives exactly one cycle after the operands are accepted, and it accepts a new operation every cycle.

Top module: `fpcmp_unit`

## Requirements
- R1: When `in_valid` is high at a clock edge, `out_valid` is high after that edge, and the matching `result` and `invalid` are available then. When `in_valid` is low, `out_valid` is low after the edge. Operations may be issued on back-to-back cycles. Reset clears `out_valid`, `result` and `invalid` to 0.
- R2: `fmt_dbl`=0 selects single precision. In that mode only `opa[31:0]` and `opb[31:0]` are used, and `result[63:32]` is 0. `fmt_dbl`=1 selects double precision, which uses all 64 bits.
- R3: The compare operation codes are `op_sel`=0 for equal, 1 for less-than and 2 for less-or-equal. A compare result sits in `result[0]` with all other bits 0. For compares, +0 and -0 are equal and neither is less than the other.
- R4: Less-than and less-or-equal return 0 and raise `invalid` when either input is any NaN. Equality returns 0 when either input is a NaN, and raises `invalid` only when an input is a signaling NaN.
- R5: `op_sel`=3 is minimum and `op_sel`=4 is maximum. Both follow numeric order, with -0 ordered below +0.
- R6: For min/max, if exactly one input is a NaN, the other operand is returned. If both inputs are NaN, the result is the canonical NaN: 0x7FC00000 in single precision and 0x7FF8000000000000 in double precision.
- R7: A signaling NaN has an all-ones exponent, a nonzero fraction and a clear top fraction bit. Min/max raises `invalid` when either input is a signaling NaN.
- R8: The `op_sel` codes 5 to 7 produce `result`=0 and `invalid`=0.
- R9: While `in_valid` is low, `result` and `invalid` keep their last values, whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and selects are valid this cycle |
| fmt_dbl | input | 1 | 0 = single precision, 1 = double precision |
| op_sel | input | 3 | 0 eq, 1 lt, 2 le, 3 min, 4 max, 5-7 reserved |
| opa | input | 64 | First operand (single precision uses bits 31:0) |
| opb | input | 64 | Second operand (single precision uses bits 31:0) |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| result | output | 64 | Compare bit in bit 0, or the selected operand |
| invalid | output | 1 | Invalid-operation flag for this result |

## Verification
The bench goes after the signed zeros. A design that compares raw bits would report +0 and -0 as unequal, and a design that ignores sign would let min/max return either zero. It drives quiet and signaling NaNs into every operation. Here a wrong design would raise `invalid` on a quiet-NaN equality, or return 1 from an unordered compare, or pass a NaN payload through where the canonical value is required. It also sends single-precision operands with junk in the upper word, which catches a design that reads those bits or leaks them into the result. It checks the hold and reset behaviour as well.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
  localparam int XLEN    = 64;
  localparam int SP_EXP  = 8;
  localparam int SP_FRAC = 23;
  localparam int DP_EXP  = 11;
  localparam int DP_FRAC = 52;
  localparam int SP_W    = 1 + SP_EXP + SP_FRAC;
  localparam int DP_W    = 1 + DP_EXP + DP_FRAC;

  typedef enum logic [2:0] {
    OP_EQ  = 3'd0,
    OP_LT  = 3'd1,
    OP_LE  = 3'd2,
    OP_MIN = 3'd3,
    OP_MAX = 3'd4
  } cmp_op_e;

  // Format-free view of one operand
  typedef struct packed {
    logic            sign;
    logic            nan;
    logic            snan;
    logic            zero;
    logic [XLEN-2:0] mag;
  } fp_info_t;

  function automatic logic [XLEN-1:0] canon_nan(input logic dbl);
    logic [XLEN-1:0] v;
    v = '0;
    if (dbl) v[DP_W-2 -: DP_EXP+1] = '1;
    else     v[SP_W-2 -: SP_EXP+1] = '1;
    return v;
  endfunction

  function automatic logic [XLEN-1:0] narrow(input logic dbl, input logic [XLEN-1:0] w);
    if (dbl) return w;
    return {{(XLEN-SP_W){1'b0}}, w[SP_W-1:0]};
  endfunction

  function automatic fp_info_t unpack_word(input logic dbl, input logic [XLEN-1:0] w);
    fp_info_t info;
    logic exp_ones, exp_none, frac_nz, frac_top;
    if (dbl) begin
      info.sign = w[DP_W-1];
      exp_ones  = &w[DP_W-2 -: DP_EXP];
      exp_none  = ~|w[DP_W-2 -: DP_EXP];
      frac_nz   = |w[DP_FRAC-1:0];
      frac_top  = w[DP_FRAC-1];
      info.mag  = w[DP_W-2:0];
    end else begin
      info.sign = w[SP_W-1];
      exp_ones  = &w[SP_W-2 -: SP_EXP];
      exp_none  = ~|w[SP_W-2 -: SP_EXP];
      frac_nz   = |w[SP_FRAC-1:0];
      frac_top  = w[SP_FRAC-1];
      info.mag  = {{(XLEN-SP_W){1'b0}}, w[SP_W-2:0]};
    end
    info.nan  = exp_ones & frac_nz;
    info.snan = exp_ones & frac_nz & ~frac_top;
    info.zero = exp_none & ~frac_nz;
    return info;
  endfunction
endpackage

// File: rtl/fp_unpack.sv
module fp_unpack
  import fpcmp_pkg::*;
(
  input  logic            fmt_dbl,
  input  logic [XLEN-1:0] word,
  output fp_info_t        info
);
  assign info = unpack_word(fmt_dbl, word);
endmodule

// File: rtl/fp_order.sv
module fp_order
  import fpcmp_pkg::*;
(
  input  fp_info_t a,
  input  fp_info_t b,
  output logic     num_lt,
  output logic     num_eq,
  output logic     mm_lt
);
  logic same_sign, both_zero, mag_lt, mag_gt, mag_eq;

  assign same_sign = (a.sign == b.sign);
  assign both_zero = a.zero & b.zero;
  assign mag_lt    = (a.mag < b.mag);
  assign mag_gt    = (a.mag > b.mag);
  assign mag_eq    = (a.mag == b.mag);

  always_comb begin
    if (both_zero)       num_lt = 1'b0;
    else if (!same_sign) num_lt = a.sign;
    else if (a.sign)     num_lt = mag_gt;
    else                 num_lt = mag_lt;
  end

  assign num_eq = both_zero | (same_sign & mag_eq);
  // min/max ordering places -0 below +0
  assign mm_lt  = num_lt | (both_zero & a.sign & ~b.sign);
endmodule

// File: rtl/fp_select.sv
module fp_select
  import fpcmp_pkg::*;
(
  input  logic            fmt_dbl,
  input  logic [2:0]      op_sel,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  fp_info_t        ia,
  input  fp_info_t        ib,
  input  logic            num_lt,
  input  logic            num_eq,
  input  logic            mm_lt,
  output logic [XLEN-1:0] res_d,
  output logic            inv_d
);
  logic            any_nan, any_snan;
  logic [XLEN-1:0] ret_a, ret_b, mm_pick;
  logic            is_max;

  assign any_nan  = ia.nan | ib.nan;
  assign any_snan = ia.snan | ib.snan;
  assign ret_a    = narrow(fmt_dbl, opa);
  assign ret_b    = narrow(fmt_dbl, opb);
  assign is_max   = (op_sel == OP_MAX);

  always_comb begin
    if (ia.nan && ib.nan) mm_pick = canon_nan(fmt_dbl);
    else if (ia.nan)      mm_pick = ret_b;
    else if (ib.nan)      mm_pick = ret_a;
    else if (is_max)      mm_pick = mm_lt ? ret_b : ret_a;
    else                  mm_pick = mm_lt ? ret_a : ret_b;
  end

  always_comb begin
    res_d = '0;
    inv_d = 1'b0;
    case (op_sel)
      OP_EQ: begin
        res_d[0] = num_eq & ~any_nan;
        inv_d    = any_snan;
      end
      OP_LT: begin
        res_d[0] = num_lt & ~any_nan;
        inv_d    = any_nan;
      end
      OP_LE: begin
        res_d[0] = (num_lt | num_eq) & ~any_nan;
        inv_d    = any_nan;
      end
      OP_MIN, OP_MAX: begin
        res_d = mm_pick;
        inv_d = any_snan;
      end
      default: begin
        res_d = '0;
        inv_d = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/fpcmp_unit.sv
module fpcmp_unit
  import fpcmp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            fmt_dbl,
  input  logic [2:0]      op_sel,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  output logic            out_valid,
  output logic [XLEN-1:0] result,
  output logic            invalid
);
  localparam int NOPS = 2;

  logic [XLEN-1:0] words [NOPS];
  fp_info_t        infos [NOPS];

  assign words[0] = opa;
  assign words[1] = opb;

  for (genvar i = 0; i < NOPS; i++) begin : g_unp
    fp_unpack u_unp (
      .fmt_dbl (fmt_dbl),
      .word    (words[i]),
      .info    (infos[i])
    );
  end

  // Named events for the checker
  logic a_nan, b_nan, a_snan, b_snan;
  assign a_nan  = infos[0].nan;
  assign b_nan  = infos[1].nan;
  assign a_snan = infos[0].snan;
  assign b_snan = infos[1].snan;

  logic num_lt, num_eq, mm_lt;
  fp_order u_ord (
    .a      (infos[0]),
    .b      (infos[1]),
    .num_lt (num_lt),
    .num_eq (num_eq),
    .mm_lt  (mm_lt)
  );

  logic [XLEN-1:0] res_d;
  logic            inv_d;
  fp_select u_sel (
    .fmt_dbl (fmt_dbl),
    .op_sel  (op_sel),
    .opa     (opa),
    .opb     (opb),
    .ia      (infos[0]),
    .ib      (infos[1]),
    .num_lt  (num_lt),
    .num_eq  (num_eq),
    .mm_lt   (mm_lt),
    .res_d   (res_d),
    .inv_d   (inv_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      invalid   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= res_d;
        invalid <= inv_d;
      end
    end
  end
endmodule

// File: rtl/fpcmp_unit_chk.sv
module fpcmp_unit_chk
  import fpcmp_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            fmt_dbl,
  input logic [2:0]      op_sel,
  input logic            a_nan,
  input logic            b_nan,
  input logic            a_snan,
  input logic            b_snan,
  input logic            out_valid,
  input logic [XLEN-1:0] result,
  input logic            invalid
);
  logic is_mm, is_ord;
  assign is_mm  = (op_sel == OP_MIN) || (op_sel == OP_MAX);
  assign is_ord = (op_sel == OP_LT) || (op_sel == OP_LE);

  AST_VALID_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R1
  AST_VALID_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R1
  AST_SP_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !fmt_dbl) |=> (result[XLEN-1:SP_W] == '0)); // R2
  AST_CMP_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel <= 3'd2) |=> (result[XLEN-1:1] == '0)); // R3
  AST_UNORDERED_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_ord && (a_nan || b_nan)) |=> (result == '0 && invalid)); // R4
  AST_CANON_NAN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_mm && a_nan && b_nan) |=> (result == canon_nan($past(fmt_dbl)))); // R6
  AST_MM_SNAN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_mm && (a_snan || b_snan)) |=> invalid); // R7
  AST_RESERVED_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel > 3'd4) |=> (result == '0 && !invalid)); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(invalid))); // R9
endmodule

bind fpcmp_unit fpcmp_unit_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .fmt_dbl   (fmt_dbl),
  .op_sel    (op_sel),
  .a_nan     (a_nan),
  .b_nan     (b_nan),
  .a_snan    (a_snan),
  .b_snan    (b_snan),
  .out_valid (out_valid),
  .result    (result),
  .invalid   (invalid)
);

// File: tb/fpcmp_unit_tb.sv
`timescale 1ns/1ps
module fpcmp_unit_tb;
  typedef struct packed {
    logic        fmt;
    logic [2:0]  op;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] res;
    logic        inv;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 27;
  localparam logic [63:0] S1   = 64'h3F800000, S2 = 64'h40000000, SM1 = 64'hBF800000;
  localparam logic [63:0] SPZ  = 64'h0, SNZ = 64'h80000000, SINF = 64'h7F800000;
  localparam logic [63:0] SQN  = 64'h7FC00001, SSN = 64'h7F800001;
  localparam logic [63:0] D1   = 64'h3FF0000000000000, D2 = 64'h4000000000000000;
  localparam logic [63:0] DM1  = 64'hBFF0000000000000, DM2 = 64'hC000000000000000;
  localparam logic [63:0] DQN  = 64'h7FF8000000000123, DSN = 64'h7FF0000000000001;

  localparam vec_t VECS [NV] = '{
    '{1'b0, 3'd0, S1,  S1,  64'd1, 1'b0, 4'd3},          // R3 eq
    '{1'b0, 3'd0, SPZ, SNZ, 64'd1, 1'b0, 4'd3},          // R3 +0 == -0
    '{1'b0, 3'd1, SM1, S1,  64'd1, 1'b0, 4'd3},          // R3 lt
    '{1'b0, 3'd1, S2,  S1,  64'd0, 1'b0, 4'd3},          // R3
    '{1'b0, 3'd2, S1,  S1,  64'd1, 1'b0, 4'd3},          // R3 le
    '{1'b0, 3'd1, SNZ, SPZ, 64'd0, 1'b0, 4'd3},          // R3 -0 not < +0
    '{1'b0, 3'd0, SQN, S1,  64'd0, 1'b0, 4'd4},          // R4 quiet eq no flag
    '{1'b0, 3'd0, SSN, S1,  64'd0, 1'b1, 4'd4},          // R4 signaling eq
    '{1'b0, 3'd1, SQN, S1,  64'd0, 1'b1, 4'd4},          // R4
    '{1'b0, 3'd2, S1,  SQN, 64'd0, 1'b1, 4'd4},          // R4
    '{1'b0, 3'd3, SNZ, SPZ, SNZ,   1'b0, 4'd5},          // R5 min zeros
    '{1'b0, 3'd4, SNZ, SPZ, SPZ,   1'b0, 4'd5},          // R5 max zeros
    '{1'b0, 3'd3, S2,  SM1, SM1,   1'b0, 4'd5},          // R5
    '{1'b0, 3'd4, S1,  SINF, SINF, 1'b0, 4'd5},          // R5
    '{1'b0, 3'd3, SQN, S2,  S2,    1'b0, 4'd6},          // R6 one NaN
    '{1'b0, 3'd4, SQN, SQN, 64'h7FC00000, 1'b0, 4'd6},   // R6 canonical
    '{1'b0, 3'd3, SSN, S1,  S1,    1'b1, 4'd7},          // R7
    '{1'b0, 3'd4, SSN, SSN, 64'h7FC00000, 1'b1, 4'd7},   // R7
    '{1'b1, 3'd1, DM2, D1,  64'd1, 1'b0, 4'd2},          // R2 double
    '{1'b1, 3'd4, D1,  D2,  D2,    1'b0, 4'd2},          // R2
    '{1'b1, 3'd3, DQN, DSN, 64'h7FF8000000000000, 1'b1, 4'd6}, // R6
    '{1'b1, 3'd2, D2,  D2,  64'd1, 1'b0, 4'd2},          // R2
    '{1'b1, 3'd1, DM2, DM1, 64'd1, 1'b0, 4'd3},          // R3 negatives
    '{1'b0, 3'd0, 64'hDEADBEEF3F800000, S1, 64'd1, 1'b0, 4'd2}, // R2 upper ignored
    '{1'b0, 3'd4, 64'hFFFFFFFF40000000, S1, S2, 1'b0, 4'd2},    // R2 upper cleared
    '{1'b0, 3'd5, S1,  S1,  64'd0, 1'b0, 4'd8},          // R8
    '{1'b1, 3'd7, D1,  D2,  64'd0, 1'b0, 4'd8}           // R8
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        fmt_dbl = 1'b0;
  logic [2:0]  op_sel = 3'd0;
  logic [63:0] opa = '0, opb = '0;
  logic        out_valid;
  logic [63:0] result;
  logic        invalid;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fpcmp_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt_dbl(fmt_dbl),
    .op_sel(op_sel), .opa(opa), .opb(opb),
    .out_valid(out_valid), .result(result), .invalid(invalid)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset out_valid", {63'd0, out_valid}, 64'd0);
    chk("R1 reset result", result, 64'd0);
    chk("R1 reset invalid", {63'd0, invalid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // back-to-back table walk
    for (int i = 0; i < NV; i++) begin
      in_valid = 1'b1;
      fmt_dbl  = VECS[i].fmt;
      op_sel   = VECS[i].op;
      opa      = VECS[i].a;
      opb      = VECS[i].b;
      @(negedge clk);
      chk($sformatf("R%0d vec%0d result", VECS[i].req, i), result, VECS[i].res);
      chk($sformatf("R%0d vec%0d invalid", VECS[i].req, i), {63'd0, invalid}, {63'd0, VECS[i].inv});
      chk($sformatf("R1 vec%0d out_valid", i), {63'd0, out_valid}, 64'd1);
    end

    // R9: idle cycle with changed operands keeps previous outputs
    in_valid = 1'b0;
    fmt_dbl  = 1'b0;
    op_sel   = 3'd4;
    opa      = S2;
    opb      = SSN;
    @(negedge clk);
    chk("R1 idle out_valid", {63'd0, out_valid}, 64'd0);
    chk("R9 idle result held", result, 64'd0);
    chk("R9 idle invalid held", {63'd0, invalid}, 64'd0);

    // R9: hold a nonzero result across two idle cycles
    in_valid = 1'b1;
    @(negedge clk);
    chk("R7 max sNaN,2 result", result, S2);
    chk("R7 max sNaN,2 invalid", {63'd0, invalid}, 64'd1);
    in_valid = 1'b0;
    op_sel   = 3'd1;
    opa      = SQN;
    opb      = D1;
    repeat (2) @(negedge clk);
    chk("R9 held result", result, S2);
    chk("R9 held invalid", {63'd0, invalid}, 64'd1);

    // R1: single-cycle pulse yields single-cycle out_valid
    in_valid = 1'b1; fmt_dbl = 1'b1; op_sel = 3'd3; opa = DM1; opb = D2;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R5 double min", result, DM1);
    chk("R1 pulse out_valid high", {63'd0, out_valid}, 64'd1);
    @(negedge clk);
    chk("R1 pulse out_valid low", {63'd0, out_valid}, 64'd0);

    // R1: reset clears outputs mid-run
    in_valid = 1'b1; op_sel = 3'd4; opa = DQN; opb = DSN;
    @(negedge clk);
    chk("R6 double canonical", result, 64'h7FF8000000000000);
    rst_n = 1'b0;
    #1;
    chk("R1 reset clears result", result, 64'd0);
    chk("R1 reset clears out_valid", {63'd0, out_valid}, 64'd0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule